// File: doc/BRIEF.md
# Nanosecond Time Base with Compare Alarm

This block keeps a free-running 64-bit signed time value in nanoseconds and makes it available to software over a 32-bit register bus. Each pulse on the `tick` input adds a fixed nanosecond step to the count. When `tick` is held low the count stops, so the time base can be paused. Software reads the count in two halves. Reading the lower half also captures the upper half in a snapshot register, so the pair that software reads always comes from the same instant.

The block also has a one-shot alarm that compares against the count as a signed value. Software first writes the upper alarm half and then the lower half. The lower-half write arms the alarm. Once the count is equal to or beyond the alarm value, the block raises a level interrupt and disarms the alarm. The interrupt stays high until software writes the interrupt-clear register. A separate register disarms a pending alarm without touching the interrupt.

Top module: `ns_timer`

## Requirements
- R1: A read of offset 0x00 returns bits 31:0 of the count at the cycle the read strobe is sampled.
- R2: A read of offset 0x04 returns the bits 63:32 that were captured by the most recent 0x00 read. It does not return the live upper half.
- R3: The count increases by STEP_NS on every clock in which `tick` is high. The count does not change while `tick` is low.
- R4: A write to 0x0C stores the upper alarm half. A write to 0x08 stores the lower half and arms the alarm. While the alarm is armed, `irq` rises once the count is equal to or greater than the alarm, compared as 64-bit signed values.
- R5: If the alarm value is already at or below the count when it is armed, `irq` rises without any further tick. A negative alarm value counts as being below a positive count.
- R6: When the alarm fires it disarms itself. `irq` then stays high until a write of any value to 0x10 lowers it. If the alarm fires in the same cycle as that write, the firing wins.
- R7: A write of any value to 0x14 disarms a pending alarm and leaves `irq` unchanged.
- R8: Reads of any other offset, and of the write-only offsets 0x08 to 0x14, return 0. Writes to any offset other than 0x08 to 0x14, including 0x00 and 0x04, have no effect.
- R9: After a synchronous reset, the count equals START_NS, the alarm is disarmed, `irq` is 0 and `bus_rdata` is 0.
- R10: `bus_rdata` is registered. It carries the result one clock after the read strobe and holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Advances the count by STEP_NS when high |
| bus_addr | input | 32 | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt from the alarm |

## Verification
The assertions assume that the bus issues at most one write per cycle, to a single address. They also assume that the count never wraps past its signed maximum during a run. The stimulus meets these assumptions in two ways. First, every access is a single-cycle strobe that the driver task separates by an idle cycle. Second, the count starts just below a 32-bit boundary and advances by only a few dozen steps. Alarm values are placed exactly on a reachable count, ahead of it, or at a negative value. This exercises the equal, future and already-passed cases of the signed compare.

// File: rtl/ns_timer_pkg.sv
package ns_timer_pkg;
  localparam logic [31:0] OFS_CNT_LO  = 32'h00;
  localparam logic [31:0] OFS_CNT_HI  = 32'h04;
  localparam logic [31:0] OFS_ALM_LO  = 32'h08;
  localparam logic [31:0] OFS_ALM_HI  = 32'h0C;
  localparam logic [31:0] OFS_IRQ_CLR = 32'h10;
  localparam logic [31:0] OFS_DISARM  = 32'h14;

  // one-hot write selects produced by the decoder
  typedef struct packed {
    logic alm_lo;
    logic alm_hi;
    logic irq_clr;
    logic disarm;
  } wr_sel_t;
endpackage

// File: rtl/ns_timer_counter.sv
module ns_timer_counter #(
  parameter int              CNT_W   = 64,
  parameter int              STEP_NS = 1,
  parameter logic [CNT_W-1:0] START  = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] STEP = CNT_W'(STEP_NS);

  always_ff @(posedge clk) begin
    if (rst)       count <= START;
    else if (tick) count <= count + STEP;
  end
endmodule

// File: rtl/ns_timer_regs.sv
module ns_timer_regs
  import ns_timer_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [31:0]       bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [CNT_W-1:0]  count,
  output wr_sel_t           wsel,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] snap_hi;
  logic              rd_lo, rd_hi;

  assign rd_lo = bus_rd && (bus_addr == OFS_CNT_LO);
  assign rd_hi = bus_rd && (bus_addr == OFS_CNT_HI);

  always_comb begin
    wsel         = '0;
    wsel.alm_lo  = bus_wr && (bus_addr == OFS_ALM_LO);
    wsel.alm_hi  = bus_wr && (bus_addr == OFS_ALM_HI);
    wsel.irq_clr = bus_wr && (bus_addr == OFS_IRQ_CLR);
    wsel.disarm  = bus_wr && (bus_addr == OFS_DISARM);
  end

  // upper half is frozen by the lower-half read
  always_ff @(posedge clk) begin
    if (rst)        snap_hi <= '0;
    else if (rd_lo) snap_hi <= count[CNT_W-1:DATA_W];
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata <= '0;
    else if (rd_lo)  rdata <= count[DATA_W-1:0];
    else if (rd_hi)  rdata <= snap_hi;
    else if (bus_rd) rdata <= '0;
  end
endmodule

// File: rtl/ns_timer_alarm.sv
module ns_timer_alarm
  import ns_timer_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  count,
  input  logic [DATA_W-1:0] wdata,
  input  wr_sel_t           wsel,
  output logic              armed,
  output logic              irq
);
  logic [DATA_W-1:0] alm_hi, alm_lo;
  logic              fire;

  assign fire = armed && ($signed(count) >= $signed({alm_hi, alm_lo}));

  always_ff @(posedge clk) begin
    if (rst) begin
      alm_hi <= '0;
      alm_lo <= '0;
    end else begin
      if (wsel.alm_hi) alm_hi <= wdata;
      if (wsel.alm_lo) alm_lo <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                      armed <= 1'b0;
    else if (wsel.alm_lo)         armed <= 1'b1;
    else if (wsel.disarm || fire) armed <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)               irq <= 1'b0;
    else if (fire)         irq <= 1'b1;
    else if (wsel.irq_clr) irq <= 1'b0;
  end
endmodule

// File: rtl/ns_timer.sv
module ns_timer
  import ns_timer_pkg::*;
#(
  parameter int                     DATA_W   = 32,
  parameter int                     STEP_NS  = 1,
  parameter logic [2*DATA_W-1:0]    START_NS = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [31:0]       bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam int CNT_W = 2 * DATA_W;

  logic [CNT_W-1:0] count;
  logic             armed;
  wr_sel_t          wsel;

  ns_timer_counter #(.CNT_W(CNT_W), .STEP_NS(STEP_NS), .START(START_NS)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .count(count)
  );

  ns_timer_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .count(count), .wsel(wsel), .rdata(bus_rdata)
  );

  ns_timer_alarm #(.DATA_W(DATA_W)) u_alarm (
    .clk(clk), .rst(rst), .count(count), .wdata(bus_wdata),
    .wsel(wsel), .armed(armed), .irq(irq)
  );
endmodule

// File: rtl/ns_timer_chk.sv
module ns_timer_chk
  import ns_timer_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int STEP_NS = 1,
  localparam int CNT_W  = 2 * DATA_W
) (
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic [31:0]       bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              irq,
  input logic [CNT_W-1:0]  count,
  input logic              armed
);
  a_r3_step: assert property (@(posedge clk) disable iff (rst)
    tick |=> count == $past(count) + CNT_W'(STEP_NS));
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(count));
  a_r4_arm: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == OFS_ALM_LO) |=> armed);
  a_r6_irq_held: assert property (@(posedge clk) disable iff (rst)
    (irq && !(bus_wr && bus_addr == OFS_IRQ_CLR)) |=> irq);
  a_r6_clear: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == OFS_IRQ_CLR && !armed) |=> !irq);
  a_r6_self_disarm: assert property (@(posedge clk) disable iff (rst)
    ($rose(irq) && !$past(bus_wr && bus_addr == OFS_ALM_LO)) |-> !armed);
  a_r7_disarm: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == OFS_DISARM) |=> !armed);
  a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr != OFS_CNT_LO && bus_addr != OFS_CNT_HI) |=> bus_rdata == '0);
  a_r10_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
endmodule

bind ns_timer ns_timer_chk #(.DATA_W(DATA_W), .STEP_NS(STEP_NS)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_rd(bus_rd), .bus_rdata(bus_rdata), .irq(irq), .count(count), .armed(armed)
);

// File: tb/test_ns_timer.sv
`timescale 1ns/1ps
module test_ns_timer;
  localparam int          STEP  = 3;
  localparam logic [63:0] START = 64'h0000_0001_FFFF_FFF0;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic [31:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [63:0] c;       // expected count
  logic [63:0] al;
  logic        rd_seen = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  ns_timer #(.DATA_W(32), .STEP_NS(STEP), .START_NS(START)) i_ns_timer (
    .clk(clk), .rst(rst), .tick(tick), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .irq(irq)
  );

  always @(posedge clk) rd_seen <= bus_rd && !rst;

  // monitor: R10 result is present one clock after the strobe
  always @(negedge clk) begin
    if (rd_seen) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (bus_rdata !== e) begin
        failures++;
        $display("FAIL %s rdata actual=%h expected=%h", t, bus_rdata, e);
      end
    end
  end

  task automatic bus_read(input logic [31:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic bus_write(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick = 1'b1;
      c = c + 64'(STEP);
    end
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic check_irq(input logic e, input string t);
    repeat (3) @(negedge clk);
    checks++;
    if (irq !== e) begin
      failures++;
      $display("FAIL %s irq actual=%b expected=%b", t, irq, e);
    end
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    c = START;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9 reset state
    checks++;
    if (irq !== 1'b0 || bus_rdata !== 32'h0) begin
      failures++;
      $display("FAIL R9 irq/rdata actual=%b/%h expected=0/0", irq, bus_rdata);
    end
    bus_read(32'h00, c[31:0], "R9 R1 start low");
    bus_read(32'h04, c[63:32], "R2 start high");
    // R3 stepping and holding
    ticks(2);
    bus_read(32'h00, c[31:0], "R3 after two ticks");
    repeat (5) @(negedge clk);
    bus_read(32'h00, c[31:0], "R3 held without tick");
    // R2 snapshot survives carry into upper half
    ticks(6);
    bus_read(32'h04, 32'h1, "R2 snapshot not live");
    bus_read(32'h00, c[31:0], "R1 low after carry");
    bus_read(32'h04, c[63:32], "R2 high after carry");
    // R8 ignored writes and unmapped reads
    bus_write(32'h00, 32'h1234);
    bus_write(32'h04, 32'h5678);
    bus_write(32'h18, 32'hFFFF);
    bus_read(32'h00, c[31:0], "R8 count untouched");
    bus_read(32'h18, 32'h0, "R8 unmapped read");
    bus_read(32'h0C, 32'h0, "R8 write-only read");
    check_irq(1'b0, "R8 no irq from stray writes");
    // R4 future alarm, exact equality
    al = c + 64'(3 * STEP);
    bus_write(32'h0C, al[63:32]);
    bus_write(32'h08, al[31:0]);
    check_irq(1'b0, "R4 armed not yet due");
    ticks(2);
    check_irq(1'b0, "R4 one step short");
    ticks(1);
    check_irq(1'b1, "R4 fires on equal");
    // R6 clear and self-disarm
    bus_write(32'h10, 32'h0);
    check_irq(1'b0, "R6 clear lowers irq");
    ticks(2);
    check_irq(1'b0, "R6 one-shot stays quiet");
    // R5 past alarm, negative value in signed compare
    bus_write(32'h0C, 32'hFFFF_FFFF);
    bus_write(32'h08, 32'h0);
    check_irq(1'b1, "R5 negative alarm fires at arm");
    // R7 disarm leaves irq high
    bus_write(32'h14, 32'h0);
    check_irq(1'b1, "R7 disarm keeps irq");
    bus_write(32'h10, 32'h0);
    check_irq(1'b0, "R6 clear after disarm");
    // R7 disarm cancels a pending alarm
    al = c + 64'(2 * STEP);
    bus_write(32'h0C, al[63:32]);
    bus_write(32'h08, al[31:0]);
    bus_write(32'h14, 32'h0);
    ticks(4);
    check_irq(1'b0, "R7 disarmed alarm silent");
    // R5 alarm equal to count at arm
    bus_write(32'h0C, c[63:32]);
    bus_write(32'h08, c[31:0]);
    check_irq(1'b1, "R5 alarm at count fires");
    bus_write(32'h10, 32'h0);
    bus_read(32'h00, c[31:0], "R1 final low");
    bus_read(32'h04, c[63:32], "R2 final high");
    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule